// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine for a small 8-bit processor that takes several cycles per instruction. The processor fetches each 32-bit instruction one byte at a time over an 8-bit datapath. It then decodes the 6-bit opcode and completes one of five instruction kinds: load byte, store byte, register-to-register ALU operation, branch if equal, and jump.

In every cycle the current state alone sets a flat set of datapath selects and enables, so these outputs carry no combinational path from the opcode. The opcode matters only at two edges. At the end of the decode state it picks the instruction path. At the end of the address state it separates a load from a store.

All pins are plain control levels. No data moves through the block, so it has no valid/ready handshake and never applies back-pressure. The datapath samples the outputs on every clock.

Top module: `mc_seq_ctrl`

## Requirements
- R1: The reset input is synchronous and active high. On the first clock after reset is released, the block is in the first fetch state: `ir_byte_we` is 4'b0001 and the fetch controls of R2 are active.
- R2: Fetch takes four consecutive cycles. `ir_byte_we` is 0001, 0010, 0100 and 1000 in turn. In each of these cycles `mem_rd`=1, `pc_upd`=1, `pc_sel`=00, `addr_from_alu`=0, `opa_sel`=0, `opb_sel`=01 and `alu_cls`=00.
- R3: The cycle after the last fetch is decode: `opa_sel`=0, `opb_sel`=11, `alu_cls`=00, and every other output is 0.
- R4: Opcodes are R-type 000000, load 100000, store 101000, branch 000100 and jump 000010. From decode, a load or store goes to the address state (`opa_sel`=1, `opb_sel`=10, `alu_cls`=00). From there a load goes to the R5 read and a store goes to the R6 store. Any other opcode sampled in the address state returns to fetch.
- R5: A load reads memory for one cycle (`mem_rd`=1, `addr_from_alu`=1). It then writes back for one cycle (`rf_we`=1, `rf_dst_sel`=0, `rf_wsrc_sel`=1) and returns to fetch.
- R6: A store writes memory for one cycle (`mem_wr`=1, `addr_from_alu`=1) and then returns to fetch.
- R7: An R-type instruction executes for one cycle (`opa_sel`=1, `opb_sel`=00, `alu_cls`=10). It then writes back for one cycle (`rf_we`=1, `rf_dst_sel`=1, `rf_wsrc_sel`=0) and returns to fetch.
- R8: A branch takes one cycle with `pc_upd_if_eq`=1, `pc_sel`=01, `opa_sel`=1, `opb_sel`=00 and `alu_cls`=01. It then returns to fetch.
- R9: A jump takes one cycle with `pc_upd`=1 and `pc_sel`=10. It then returns to fetch.
- R10: An opcode outside the five listed in R4, sampled at the end of decode, returns the block to the first fetch state.
- R11: In each state, every output not named for that state is 0. In particular, `mem_rd` and `mem_wr` are never both 1, and a register write never coincides with any memory access or PC update.
- R12: The opcode is ignored outside decode and the address state. Changing it during fetch leaves the fetch sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| ir_byte_we | output | 4 | One-hot write enable per instruction byte |
| pc_upd | output | 1 | Unconditional program counter write |
| pc_upd_if_eq | output | 1 | Program counter write when the ALU reports equality |
| pc_sel | output | 2 | Next PC source: 00 ALU result, 01 registered ALU result, 10 jump target |
| addr_from_alu | output | 1 | Memory address from the ALU register (1) or the PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| opa_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| opb_sel | output | 2 | ALU operand B: 00 register B, 01 constant one, 10 immediate, 11 branch offset |
| alu_cls | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| rf_we | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination register field: 0 second source field, 1 destination field |
| rf_wsrc_sel | output | 1 | Write-back data: 0 ALU register, 1 memory data register |

## Verification
The assertions assume that `opcode` holds a defined 0/1 value at every rising edge once reset is released, and that reset is held for at least one edge before release. The assertions never constrain the opcode itself. They relate output patterns in successive cycles, such as a write-back following a read or a return to fetch after each completion. The stimulus changes the opcode only at falling edges. It draws from the five legal codes and from arbitrary 6-bit values, so unknown codes reach both decode and the fetch cycles. Reset is applied only at defined points.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int OP_W    = 6;
  localparam int FETCH_N = 4;
  localparam int ST_W    = 4;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000,
                              OPC_LOAD  = 6'b100000,
                              OPC_STORE = 6'b101000,
                              OPC_BEQ   = 6'b000100,
                              OPC_JUMP  = 6'b000010;

  localparam logic [ST_W-1:0] S_FETCH0 = '0,
                              S_LAST_F = ST_W'(FETCH_N - 1),
                              S_DECODE = ST_W'(FETCH_N),
                              S_ADDR   = ST_W'(FETCH_N + 1),
                              S_MEMRD  = ST_W'(FETCH_N + 2),
                              S_LDWB   = ST_W'(FETCH_N + 3),
                              S_STORE  = ST_W'(FETCH_N + 4),
                              S_EXEC   = ST_W'(FETCH_N + 5),
                              S_RWB    = ST_W'(FETCH_N + 6),
                              S_BRANCH = ST_W'(FETCH_N + 7),
                              S_JUMP   = ST_W'(FETCH_N + 8);

  localparam logic [1:0] PCS_ALU = 2'b00, PCS_ALUREG = 2'b01, PCS_JUMP = 2'b10;
  localparam logic [1:0] OPB_REG = 2'b00, OPB_ONE = 2'b01, OPB_IMM = 2'b10, OPB_OFFS = 2'b11;
  localparam logic [1:0] CLS_ADD = 2'b00, CLS_SUB = 2'b01, CLS_FUNCT = 2'b10;

  typedef struct packed {
    logic [FETCH_N-1:0] ir_we;
    logic               pc_upd;
    logic               pc_upd_if_eq;
    logic [1:0]         pc_sel;
    logic               addr_from_alu;
    logic               mem_rd;
    logic               mem_wr;
    logic               opa_sel;
    logic [1:0]         opb_sel;
    logic [1:0]         alu_cls;
    logic               rf_we;
    logic               rf_dst_sel;
    logic               rf_wsrc_sel;
  } ctrl_t;
endpackage

// File: rtl/mcs_state_reg.sv
module mcs_state_reg #(
  parameter int            W       = 4,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/mcs_next_state.sv
module mcs_next_state
  import mcs_pkg::*;
(
  input  logic [ST_W-1:0] st,
  input  logic [OP_W-1:0] opcode,
  output logic [ST_W-1:0] st_nxt
);
  always_comb begin
    st_nxt = S_FETCH0;
    if (st < S_LAST_F) begin
      st_nxt = st + ST_W'(1);
    end else begin
      case (st)
        S_LAST_F: st_nxt = S_DECODE;
        S_DECODE: begin
          case (opcode)
            OPC_LOAD, OPC_STORE: st_nxt = S_ADDR;
            OPC_RTYPE:           st_nxt = S_EXEC;
            OPC_BEQ:             st_nxt = S_BRANCH;
            OPC_JUMP:            st_nxt = S_JUMP;
            default:             st_nxt = S_FETCH0;
          endcase
        end
        S_ADDR: begin
          if (opcode == OPC_LOAD)       st_nxt = S_MEMRD;
          else if (opcode == OPC_STORE) st_nxt = S_STORE;
          else                          st_nxt = S_FETCH0;
        end
        S_MEMRD: st_nxt = S_LDWB;
        S_EXEC:  st_nxt = S_RWB;
        default: st_nxt = S_FETCH0;
      endcase
    end
  end
endmodule

// File: rtl/mcs_out_decode.sv
module mcs_out_decode
  import mcs_pkg::*;
(
  input  logic [ST_W-1:0] st,
  output ctrl_t           ctl
);
  logic [FETCH_N-1:0] fetch_hot;

  for (genvar k = 0; k < FETCH_N; k++) begin : g_fetch
    assign fetch_hot[k] = (st == ST_W'(k));
  end

  always_comb begin
    ctl = '0;
    if (|fetch_hot) begin
      ctl.ir_we   = fetch_hot;
      ctl.mem_rd  = 1'b1;
      ctl.pc_upd  = 1'b1;
      ctl.pc_sel  = PCS_ALU;
      ctl.opb_sel = OPB_ONE;
      ctl.alu_cls = CLS_ADD;
    end else begin
      case (st)
        S_DECODE: begin
          ctl.opb_sel = OPB_OFFS;
          ctl.alu_cls = CLS_ADD;
        end
        S_ADDR: begin
          ctl.opa_sel = 1'b1;
          ctl.opb_sel = OPB_IMM;
          ctl.alu_cls = CLS_ADD;
        end
        S_MEMRD: begin
          ctl.mem_rd        = 1'b1;
          ctl.addr_from_alu = 1'b1;
        end
        S_LDWB: begin
          ctl.rf_we       = 1'b1;
          ctl.rf_wsrc_sel = 1'b1;
        end
        S_STORE: begin
          ctl.mem_wr        = 1'b1;
          ctl.addr_from_alu = 1'b1;
        end
        S_EXEC: begin
          ctl.opa_sel = 1'b1;
          ctl.opb_sel = OPB_REG;
          ctl.alu_cls = CLS_FUNCT;
        end
        S_RWB: begin
          ctl.rf_we      = 1'b1;
          ctl.rf_dst_sel = 1'b1;
        end
        S_BRANCH: begin
          ctl.opa_sel      = 1'b1;
          ctl.opb_sel      = OPB_REG;
          ctl.alu_cls      = CLS_SUB;
          ctl.pc_upd_if_eq = 1'b1;
          ctl.pc_sel       = PCS_ALUREG;
        end
        S_JUMP: begin
          ctl.pc_upd = 1'b1;
          ctl.pc_sel = PCS_JUMP;
        end
        default: ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_W-1:0]     opcode,
  output logic [FETCH_N-1:0]  ir_byte_we,
  output logic                pc_upd,
  output logic                pc_upd_if_eq,
  output logic [1:0]          pc_sel,
  output logic                addr_from_alu,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                opa_sel,
  output logic [1:0]          opb_sel,
  output logic [1:0]          alu_cls,
  output logic                rf_we,
  output logic                rf_dst_sel,
  output logic                rf_wsrc_sel
);
  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] st_d;
  ctrl_t           ctl;

  mcs_state_reg #(.W(ST_W), .RST_VAL(S_FETCH0)) u_state (
    .clk (clk),
    .rst (rst),
    .d   (st_d),
    .q   (st_q)
  );

  mcs_next_state u_next (
    .st     (st_q),
    .opcode (opcode),
    .st_nxt (st_d)
  );

  mcs_out_decode u_dec (
    .st  (st_q),
    .ctl (ctl)
  );

  assign ir_byte_we    = ctl.ir_we;
  assign pc_upd        = ctl.pc_upd;
  assign pc_upd_if_eq  = ctl.pc_upd_if_eq;
  assign pc_sel        = ctl.pc_sel;
  assign addr_from_alu = ctl.addr_from_alu;
  assign mem_rd        = ctl.mem_rd;
  assign mem_wr        = ctl.mem_wr;
  assign opa_sel       = ctl.opa_sel;
  assign opb_sel       = ctl.opb_sel;
  assign alu_cls       = ctl.alu_cls;
  assign rf_we         = ctl.rf_we;
  assign rf_dst_sel    = ctl.rf_dst_sel;
  assign rf_wsrc_sel   = ctl.rf_wsrc_sel;
endmodule

// File: rtl/mc_seq_ctrl_chk.sv
module mc_seq_ctrl_chk
  import mcs_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [FETCH_N-1:0] ir_byte_we,
  input logic               pc_upd,
  input logic               pc_upd_if_eq,
  input logic [1:0]         pc_sel,
  input logic               addr_from_alu,
  input logic               mem_rd,
  input logic               mem_wr,
  input logic [1:0]         opb_sel,
  input logic [1:0]         alu_cls,
  input logic               rf_we,
  input logic               rf_dst_sel,
  input logic               rf_wsrc_sel
);
  // R1
  reset_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ir_byte_we == FETCH_N'(1)) && mem_rd && pc_upd);

  // R2
  fetch_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ir_byte_we));

  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
    (ir_byte_we != '0 && !ir_byte_we[FETCH_N-1]) |=> (ir_byte_we == ($past(ir_byte_we) << 1)));

  // R3
  decode_follows_chk: assert property (@(posedge clk) disable iff (rst)
    ir_byte_we[FETCH_N-1] |=> (opb_sel == OPB_OFFS) && !mem_rd && !pc_upd);

  // R5
  load_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we && rf_wsrc_sel) |-> $past(mem_rd && addr_from_alu));

  // R7
  rtype_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we && rf_dst_sel) |-> $past(alu_cls == CLS_FUNCT));

  // R8
  branch_after_decode_chk: assert property (@(posedge clk) disable iff (rst)
    pc_upd_if_eq |-> $past(opb_sel == OPB_OFFS));

  // R9
  jump_after_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_upd && pc_sel == PCS_JUMP) |-> $past(opb_sel == OPB_OFFS));

  // R11
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R6
  complete_return_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we || mem_wr || pc_upd_if_eq || (pc_upd && pc_sel == PCS_JUMP)) |=> (ir_byte_we == FETCH_N'(1)));
endmodule

bind mc_seq_ctrl mc_seq_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .ir_byte_we    (ir_byte_we),
  .pc_upd        (pc_upd),
  .pc_upd_if_eq  (pc_upd_if_eq),
  .pc_sel        (pc_sel),
  .addr_from_alu (addr_from_alu),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .opb_sel       (opb_sel),
  .alu_cls       (alu_cls),
  .rf_we         (rf_we),
  .rf_dst_sel    (rf_dst_sel),
  .rf_wsrc_sel   (rf_wsrc_sel)
);

// File: tb/mc_seq_ctrl_test.sv
`timescale 1ns/1ps
module mc_seq_ctrl_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst;
  logic [5:0] opcode;
  logic [3:0] ir_byte_we;
  logic       pc_upd, pc_upd_if_eq, addr_from_alu, mem_rd, mem_wr, opa_sel;
  logic       rf_we, rf_dst_sel, rf_wsrc_sel;
  logic [1:0] pc_sel, opb_sel, alu_cls;

  mc_seq_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode), .ir_byte_we(ir_byte_we),
    .pc_upd(pc_upd), .pc_upd_if_eq(pc_upd_if_eq), .pc_sel(pc_sel),
    .addr_from_alu(addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .opa_sel(opa_sel), .opb_sel(opb_sel), .alu_cls(alu_cls),
    .rf_we(rf_we), .rf_dst_sel(rf_dst_sel), .rf_wsrc_sel(rf_wsrc_sel)
  );

  localparam logic [5:0] RT = 6'b000000, LD = 6'b100000, ST = 6'b101000,
                         BQ = 6'b000100, JP = 6'b000010;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int m_st  = 0;

  function automatic logic [18:0] mk(input logic [3:0] ir, input logic pu, pe,
      input logic [1:0] ps, input logic ia, mr, mw, oa, input logic [1:0] ob, ac,
      input logic rw, rd, rs);
    return {ir, pu, pe, ps, ia, mr, mw, oa, ob, ac, rw, rd, rs};
  endfunction

  function automatic logic [18:0] exp_vec(input int s);
    if (s < 4) return mk(4'(1 << s), 1, 0, 2'b00, 0, 1, 0, 0, 2'b01, 2'b00, 0, 0, 0);
    case (s)
      4:  return mk(4'b0, 0, 0, 2'b00, 0, 0, 0, 0, 2'b11, 2'b00, 0, 0, 0);
      5:  return mk(4'b0, 0, 0, 2'b00, 0, 0, 0, 1, 2'b10, 2'b00, 0, 0, 0);
      6:  return mk(4'b0, 0, 0, 2'b00, 1, 1, 0, 0, 2'b00, 2'b00, 0, 0, 0);
      7:  return mk(4'b0, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00, 2'b00, 1, 0, 1);
      8:  return mk(4'b0, 0, 0, 2'b00, 1, 0, 1, 0, 2'b00, 2'b00, 0, 0, 0);
      9:  return mk(4'b0, 0, 0, 2'b00, 0, 0, 0, 1, 2'b00, 2'b10, 0, 0, 0);
      10: return mk(4'b0, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00, 2'b00, 1, 1, 0);
      11: return mk(4'b0, 0, 1, 2'b01, 0, 0, 0, 1, 2'b00, 2'b01, 0, 0, 0);
      default: return mk(4'b0, 1, 0, 2'b10, 0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0);
    endcase
  endfunction

  function automatic int nxt(input int s, input logic [5:0] op);
    if (s < 4) return s + 1;
    if (s == 4) begin
      if (op == LD || op == ST) return 5;
      if (op == RT) return 9;
      if (op == BQ) return 11;
      if (op == JP) return 12;
      return 0;
    end
    if (s == 5) return (op == LD) ? 6 : (op == ST) ? 8 : 0;
    if (s == 6) return 7;
    if (s == 9) return 10;
    return 0;
  endfunction

  function automatic string tag_of(input int s);
    if (s < 4)  return "R2";
    if (s == 4) return "R3";
    if (s == 5) return "R4";
    if (s == 6 || s == 7) return "R5";
    if (s == 8) return "R6";
    if (s == 9 || s == 10) return "R7";
    if (s == 11) return "R8";
    return "R9";
  endfunction

  function automatic bit legal(input logic [5:0] op);
    return op == RT || op == LD || op == ST || op == BQ || op == JP;
  endfunction

  task automatic step(input logic r, input logic [5:0] op, input string ovr);
    string t;
    logic [18:0] act, ex;
    t = ovr;
    if (t == "" && r) t = "R1";
    if (t == "" && m_st == 4 && !legal(op)) t = "R10";
    rst = r;
    opcode = op;
    @(posedge clk);
    m_st = r ? 0 : nxt(m_st, op);
    @(negedge clk);
    if (t == "") t = tag_of(m_st);
    act = {ir_byte_we, pc_upd, pc_upd_if_eq, pc_sel, addr_from_alu, mem_rd, mem_wr,
           opa_sel, opb_sel, alu_cls, rf_we, rf_dst_sel, rf_wsrc_sel};
    ex = exp_vec(m_st);
    n_chk++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s model state %0d: actual %b expected %b", t, m_st, act, ex);
    end
    // R11: a register write excludes memory access and PC updates
    n_chk++;
    if (rf_we && (mem_rd || mem_wr || pc_upd || pc_upd_if_eq)) begin
      n_bad++;
      $display("FAIL R11 exclusive outputs: actual %b expected no overlap", act);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] seq [6];
    int unsigned seed;
    seed = $urandom(32'h0000_5eed);
    seq = '{LD, ST, RT, BQ, JP, 6'b111111};
    rst = 1'b1;
    opcode = RT;
    @(negedge clk);
    step(1'b1, RT, "R1");
    step(1'b1, RT, "R1");
    // directed: each instruction kind, then an unknown opcode (R10)
    foreach (seq[i]) begin
      do step(1'b0, seq[i], ""); while (m_st != 0);
    end
    // R12: opcode churn during fetch does not disturb the sequence
    for (int i = 0; i < 4; i++) step(1'b0, 6'($urandom), "R12");
    step(1'b0, LD, "");
    // R4: opcode changes from load to jump in the address state
    step(1'b0, JP, "R4");
    // random mix with occasional reset
    for (int i = 0; i < 600; i++) begin
      int unsigned k;
      logic [5:0] op;
      k = $urandom % 8;
      case (k)
        0: op = RT;
        1: op = LD;
        2: op = ST;
        3: op = BQ;
        4: op = JP;
        default: op = 6'($urandom);
      endcase
      step(($urandom % 60) == 0, op, "");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule